// File: doc/BRIEF.md
# Filtered Quadrature Decoder Front End

This block sits between an incremental encoder and a position counter. It takes the two encoder channels A and B and an active-low index line, all assumed synchronous to the block clock. Each line passes through a glitch filter that runs on a filter tick derived from that clock. The filtered A/B pair is then turned into single-cycle count pulses with a direction bit, at one, two or four counts per encoder cycle. A separate mode bypasses the filter and treats A as a count clock and B as the direction.

The index line produces a one-cycle strobe. In synchronous operation the strobe is qualified by the filtered A/B phase. In asynchronous operation it is taken straight from the raw line. A count-clock copy is provided for observation. The counter itself and any register interface belong to the surrounding logic.

All outputs are registered. In quadrature modes a clean step at the inputs, with the tick running every clock, shows up on the outputs after the third rising edge that samples it.

Top module: `qd_front`

## Requirements
- R1: During and after reset `cnt_pulse`, `cnt_up`, `idx_strobe` and `cko` are all 0 until an input event occurs.
- R2: With `res_mode` = 2'b00 (non-quadrature), a rising edge of `enc_a` gives one `cnt_pulse` in the cycle after the clock edge that first samples A high. `cnt_up` in that cycle equals `enc_b` as sampled at that edge (1 = up).
- R3: In non-quadrature mode the filter is bypassed: an `enc_a` high level lasting a single clock is still counted.
- R4: In quadrature modes the (A,B) order 00→10→11→01→00 (A leading B) counts up and the reverse order counts down. `cnt_up` holds the direction of the most recent pulse.
- R5: `res_mode` 2'b01 counts only the steps between (A,B)=00 and 10 (x1). 2'b10 counts every step that changes A (x2). 2'b11 counts every valid step (x4). A full cycle forward and back gives zero net count.
- R6: A change in which filtered A and B both move at the same sample is invalid and gives no pulse.
- R7: A new input level is accepted after two consecutive equal filter-tick samples. With the tick running every clock, a single x4 step gives `cnt_pulse` high after the third rising edge that sees it, and low after the first two. A one-clock glitch gives no pulse.
- R8: `fdiv` = 1 halves the filter tick rate, so a level held for only two clocks is never accepted. With `fdiv` = 0 the same two-clock pulse is accepted.
- R9: With `idx_sync` = 1 in a quadrature mode, one `idx_strobe` is issued when the filtered index is low while filtered A equals filtered B. The strobe falls in the same cycle as the count pulse of the step that completes the phase.
- R10: With `idx_sync` = 0, or in non-quadrature mode whatever `idx_sync` is, `idx_strobe` pulses once in the cycle after the first edge that samples `enc_idx_n` low, at any A/B phase.
- R11: With `idx_enable` = 0 no `idx_strobe` is produced.
- R12: In quadrature modes `cko` pulses exactly with each count pulse. In non-quadrature mode `cko` follows `enc_a` one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; also the prescale source of the filter tick |
| rst_n | input | 1 | Active-low synchronous reset |
| enc_a | input | 1 | Encoder channel A (count clock in non-quadrature mode) |
| enc_b | input | 1 | Encoder channel B (direction in non-quadrature mode, 1 = up) |
| enc_idx_n | input | 1 | Index input, active low |
| res_mode | input | 2 | 00 non-quadrature, 01 x1, 10 x2, 11 x4 |
| fdiv | input | PRESCALE_W | Filter tick divide code; tick every fdiv+1 clocks |
| idx_enable | input | 1 | 1 enables index strobes |
| idx_sync | input | 1 | 1 selects phase-qualified synchronous index |
| cnt_pulse | output | 1 | One-cycle count request |
| cnt_up | output | 1 | Direction of the current/last count, 1 = up |
| idx_strobe | output | 1 | One-cycle index event |
| cko | output | 1 | Copy of the internal count clock |

## Verification
The index strobe and a count pulse can land in the same cycle. This happens when a synchronous index is held low while the encoder steps into the 11 phase, because both outputs are produced from the same filtered sample. The bench holds the index low at a phase where A differs from B, checks that no strobe appears, and then steps to the equal phase. It judges the result by counting cycles at the output where both signals are high together, and by checking that the net position and the total strobe count are unchanged by the overlap.

// File: rtl/qd_pkg.sv
package qd_pkg;

    typedef enum logic [1:0] {
        RES_NQ = 2'b00,
        RES_X1 = 2'b01,
        RES_X2 = 2'b10,
        RES_X4 = 2'b11
    } res_e;

    // (A,B) level pair to position on the four-phase cycle, forward = up
    function automatic logic [1:0] phase_of(input logic [1:0] ab);
        return {ab[0], ab[1] ^ ab[0]};
    endfunction

endpackage

// File: rtl/qd_tick.sv
module qd_tick #(
    parameter int PRESCALE_W = 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [PRESCALE_W-1:0] div_code,
    output logic                  tick
);
    typedef struct packed {
        logic [PRESCALE_W-1:0] cnt;
    } st_t;

    st_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        tick = (st_q.cnt >= div_code);
        if (tick) st_d.cnt = '0;
        else      st_d.cnt = st_q.cnt + PRESCALE_W'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/qd_filter_bit.sv
module qd_filter_bit #(
    parameter int   STABLE_TICKS = 2,
    parameter logic RST_LEVEL    = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic raw,
    output logic level
);
    localparam int RUN_W = $clog2(STABLE_TICKS + 1);

    typedef struct packed {
        logic             smp;
        logic             lvl;
        logic [RUN_W-1:0] run;
    } st_t;

    st_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (tick) begin
            if (raw == st_q.smp) begin
                if (st_q.run < RUN_W'(STABLE_TICKS))
                    st_d.run = st_q.run + RUN_W'(1);
            end else begin
                st_d.smp = raw;
                st_d.run = RUN_W'(1);
            end
            if (st_d.run >= RUN_W'(STABLE_TICKS))
                st_d.lvl = st_d.smp;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.smp <= RST_LEVEL;
            st_q.lvl <= RST_LEVEL;
            st_q.run <= RUN_W'(STABLE_TICKS);
        end else begin
            st_q <= st_d;
        end
    end

    assign level = st_q.lvl;
endmodule

// File: rtl/qd_filter.sv
module qd_filter #(
    parameter int             WIDTH        = 3,
    parameter int             STABLE_TICKS = 2,
    parameter logic [WIDTH-1:0] RST_LEVELS = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [WIDTH-1:0] raw,
    output logic [WIDTH-1:0] level
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        qd_filter_bit #(
            .STABLE_TICKS (STABLE_TICKS),
            .RST_LEVEL    (RST_LEVELS[i])
        ) u_bit (
            .clk   (clk),
            .rst_n (rst_n),
            .tick  (tick),
            .raw   (raw[i]),
            .level (level[i])
        );
    end
endmodule

// File: rtl/qd_decode.sv
module qd_decode
    import qd_pkg::*;
(
    input  logic [1:0] res_mode,
    input  logic [1:0] ab_new,
    input  logic [1:0] ab_old,
    output logic       pulse,
    output logic       up
);
    logic [1:0] ph_new, ph_old, delta;
    logic       step_up, step_dn, a_moved, x1_edge;

    always_comb begin
        ph_new  = phase_of(ab_new);
        ph_old  = phase_of(ab_old);
        delta   = ph_new - ph_old;
        step_up = (delta == 2'd1);
        step_dn = (delta == 2'd3);
        a_moved = ab_new[1] ^ ab_old[1];
        x1_edge = ((ph_old == 2'd0) && (ph_new == 2'd1)) ||
                  ((ph_old == 2'd1) && (ph_new == 2'd0));
        unique case (res_e'(res_mode))
            RES_X4:  pulse = step_up | step_dn;
            RES_X2:  pulse = (step_up | step_dn) & a_moved;
            RES_X1:  pulse = (step_up | step_dn) & x1_edge;
            default: pulse = 1'b0;
        endcase
        up = step_up;
    end
endmodule

// File: rtl/qd_front.sv
module qd_front
    import qd_pkg::*;
#(
    parameter int STABLE_TICKS = 2,
    parameter int PRESCALE_W   = 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  enc_a,
    input  logic                  enc_b,
    input  logic                  enc_idx_n,
    input  logic [1:0]            res_mode,
    input  logic [PRESCALE_W-1:0] fdiv,
    input  logic                  idx_enable,
    input  logic                  idx_sync,
    output logic                  cnt_pulse,
    output logic                  cnt_up,
    output logic                  idx_strobe,
    output logic                  cko
);
    localparam int         NLINES    = 3;
    localparam logic [2:0] LINE_RST  = 3'b001;

    typedef struct packed {
        logic [1:0] ab_prev;
        logic       a_raw_prev;
        logic       idx_raw_prev;
        logic       qual_prev;
        logic       pulse;
        logic       up;
        logic       strobe;
        logic       cko;
    } st_t;

    st_t st_q, st_d;

    logic              tick;
    logic [NLINES-1:0] flt;
    logic [1:0]        flt_ab;
    logic              flt_idx_n;
    logic              dec_pulse, dec_up;
    logic              quad, qual, nq_rise, async_fall;

    qd_tick #(.PRESCALE_W(PRESCALE_W)) u_tick (
        .clk      (clk),
        .rst_n    (rst_n),
        .div_code (fdiv),
        .tick     (tick)
    );

    qd_filter #(
        .WIDTH        (NLINES),
        .STABLE_TICKS (STABLE_TICKS),
        .RST_LEVELS   (LINE_RST)
    ) u_filter (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .raw   ({enc_a, enc_b, enc_idx_n}),
        .level (flt)
    );

    assign flt_ab    = flt[2:1];
    assign flt_idx_n = flt[0];

    qd_decode u_decode (
        .res_mode (res_mode),
        .ab_new   (flt_ab),
        .ab_old   (st_q.ab_prev),
        .pulse    (dec_pulse),
        .up       (dec_up)
    );

    always_comb begin
        st_d       = st_q;
        quad       = (res_mode != RES_NQ);
        qual       = idx_enable & ~flt_idx_n & (flt_ab[1] == flt_ab[0]);
        nq_rise    = enc_a & ~st_q.a_raw_prev;
        async_fall = idx_enable & ~enc_idx_n & st_q.idx_raw_prev;

        st_d.ab_prev      = flt_ab;
        st_d.a_raw_prev   = enc_a;
        st_d.idx_raw_prev = enc_idx_n;
        st_d.qual_prev    = qual;

        if (quad) begin
            st_d.pulse = dec_pulse;
            st_d.cko   = dec_pulse;
            if (dec_pulse) st_d.up = dec_up;
        end else begin
            st_d.pulse = nq_rise;
            st_d.cko   = enc_a;
            if (nq_rise) st_d.up = enc_b;
        end

        if (quad && idx_sync) st_d.strobe = qual & ~st_q.qual_prev;
        else                  st_d.strobe = async_fall;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q              <= '0;
            st_q.idx_raw_prev <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_pulse  = st_q.pulse;
    assign cnt_up     = st_q.up;
    assign idx_strobe = st_q.strobe;
    assign cko        = st_q.cko;
endmodule

// File: rtl/qd_front_chk.sv
module qd_front_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       enc_a,
    input logic       enc_b,
    input logic [1:0] res_mode,
    input logic       idx_enable,
    input logic       idx_sync,
    input logic [1:0] flt_ab,
    input logic       cnt_pulse,
    input logic       cnt_up,
    input logic       idx_strobe
);
    // R3: bypassed A still needs a low cycle between two counts
    assert_nq_spacing_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_pulse && res_mode == 2'b00 && $past(res_mode) == 2'b00) |=> !cnt_pulse);

    // R2: non-quadrature pulse follows an A rise and carries B
    assert_nq_dir_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_pulse && $past(res_mode) == 2'b00) |->
            (cnt_up == $past(enc_b) && $past(enc_a)));

    // R11: disabled index never strobes
    assert_idx_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!idx_enable) |-> !idx_strobe);

    // R9: synchronous strobe only at an equal filtered A/B phase
    assert_sync_phase_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (idx_strobe && $past(idx_sync) && $past(res_mode) != 2'b00) |->
            ($past(flt_ab) == 2'b00 || $past(flt_ab) == 2'b11));

    // R6: a quadrature pulse needs a one-line change of the filtered pair
    assert_quad_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_pulse && $past(res_mode) != 2'b00) |->
            $countones($past(flt_ab) ^ $past(flt_ab, 2)) == 1);
endmodule

bind qd_front qd_front_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .enc_a      (enc_a),
    .enc_b      (enc_b),
    .res_mode   (res_mode),
    .idx_enable (idx_enable),
    .idx_sync   (idx_sync),
    .flt_ab     (flt_ab),
    .cnt_pulse  (cnt_pulse),
    .cnt_up     (cnt_up),
    .idx_strobe (idx_strobe)
);

// File: tb/qd_front_bench.sv
`timescale 1ns/1ps
module qd_front_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enc_a = 1'b0;
    logic       enc_b = 1'b0;
    logic       enc_idx_n = 1'b1;
    logic [1:0] res_mode = 2'b11;
    logic [0:0] fdiv = 1'b0;
    logic       idx_enable = 1'b1;
    logic       idx_sync = 1'b0;
    logic       cnt_pulse, cnt_up, idx_strobe, cko;

    int nchk = 0;
    int nfail = 0;
    int pos = 0, npulse = 0, nidx = 0, nboth = 0, ncko = 0;
    int gidx = 0;

    always #4 clk = ~clk;

    qd_front u_qd_front (
        .clk        (clk),
        .rst_n      (rst_n),
        .enc_a      (enc_a),
        .enc_b      (enc_b),
        .enc_idx_n  (enc_idx_n),
        .res_mode   (res_mode),
        .fdiv       (fdiv),
        .idx_enable (idx_enable),
        .idx_sync   (idx_sync),
        .cnt_pulse  (cnt_pulse),
        .cnt_up     (cnt_up),
        .idx_strobe (idx_strobe),
        .cko        (cko)
    );

    always @(negedge clk) begin
        if (rst_n) begin
            if (cnt_pulse) begin
                npulse++;
                pos += cnt_up ? 1 : -1;
            end
            if (idx_strobe) nidx++;
            if (cnt_pulse && idx_strobe) nboth++;
            if (cko) ncko++;
        end
    end

    task automatic check(input string what, input int got, input int exp);
        nchk++;
        if (got != exp) begin
            nfail++;
            $display("FAIL %s: got %0d expected %0d", what, got, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic drive_phase(input int g);
        enc_a = (g == 1) || (g == 2);
        enc_b = (g == 2) || (g == 3);
    endtask

    task automatic step(input int dir);
        gidx = (gidx + dir) & 3;
        drive_phase(gidx);
        wait_cyc(10);
    endtask

    task automatic finish_run;
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nchk++;
        nfail++;
        $display("FAIL R1 watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        int p0, n0, c0, i0, b0, expn, sum;
        wait_cyc(4);
        check("R1 reset pulse", cnt_pulse, 0);
        check("R1 reset strobe", idx_strobe, 0);
        rst_n = 1'b1;
        wait_cyc(1);
        check("R1 after reset pulse", cnt_pulse, 0);
        check("R1 after reset dir", cnt_up, 0);
        check("R1 after reset strobe", idx_strobe, 0);
        check("R1 after reset cko", cko, 0);
        wait_cyc(6);

        // R4 R5 R12: resolution and divide sweep
        for (int m = 1; m < 4; m++) begin
            for (int dv = 0; dv < 2; dv++) begin
                res_mode = m[1:0];
                fdiv = dv[0:0];
                wait_cyc(10);
                p0 = pos; n0 = npulse; c0 = ncko;
                repeat (12) step(1);
                expn = (m == 3) ? 12 : (m == 2) ? 6 : 3;
                check($sformatf("R5 up count mode %0d div %0d", m, dv), pos - p0, expn);
                check("R4 direction up", cnt_up, 1);
                repeat (12) step(-1);
                check($sformatf("R5 round trip mode %0d div %0d", m, dv), pos - p0, 0);
                check("R4 direction down", cnt_up, 0);
                check("R5 pulse total", npulse - n0, 2 * expn);
                check("R12 cko matches pulses", ncko - c0, 2 * expn);
            end
        end

        // R7: latency and single-clock glitch, tick every clock
        res_mode = 2'b11; fdiv = 1'b0; wait_cyc(10);
        gidx = 1; drive_phase(gidx);
        wait_cyc(1); check("R7 latency edge 1", cnt_pulse, 0);
        wait_cyc(1); check("R7 latency edge 2", cnt_pulse, 0);
        wait_cyc(1); check("R7 latency edge 3", cnt_pulse, 1);
        wait_cyc(8);
        step(-1);
        n0 = npulse;
        enc_a = 1'b1; wait_cyc(1); enc_a = 1'b0; wait_cyc(10);
        check("R7 one-clock glitch", npulse - n0, 0);

        // R8: two-clock pulse accepted at full rate, rejected at half rate
        n0 = npulse; p0 = pos;
        enc_a = 1'b1; wait_cyc(2); enc_a = 1'b0; wait_cyc(10);
        check("R8 two-clock pulse full rate", npulse - n0, 2);
        check("R8 two-clock pulse net", pos - p0, 0);
        fdiv = 1'b1; wait_cyc(6);
        n0 = npulse;
        enc_a = 1'b1; wait_cyc(2); enc_a = 1'b0; wait_cyc(12);
        check("R8 two-clock pulse half rate", npulse - n0, 0);
        fdiv = 1'b0; wait_cyc(6);

        // R6: both lines change together
        n0 = npulse;
        enc_a = 1'b1; enc_b = 1'b1; gidx = 2; wait_cyc(10);
        enc_a = 1'b0; enc_b = 1'b0; gidx = 0; wait_cyc(10);
        check("R6 invalid double change", npulse - n0, 0);

        // R10: asynchronous index at unequal phase
        idx_sync = 1'b0;
        step(1);
        i0 = nidx;
        enc_idx_n = 1'b0;
        wait_cyc(1); check("R10 async strobe timing", idx_strobe, 1);
        wait_cyc(6);
        check("R10 async single strobe", nidx - i0, 1);
        enc_idx_n = 1'b1; wait_cyc(10);

        // R9: synchronous index waits for equal phase, coincides with count
        idx_sync = 1'b1; wait_cyc(4);
        i0 = nidx; b0 = nboth;
        enc_idx_n = 1'b0; wait_cyc(10);
        check("R9 sync blocked at A!=B", nidx - i0, 0);
        step(1);
        check("R9 sync strobe at A=B=1", nidx - i0, 1);
        check("R9 strobe with count same cycle", nboth - b0, 1);
        enc_idx_n = 1'b1; wait_cyc(10);
        step(-1); step(-1);
        i0 = nidx;
        enc_idx_n = 1'b0; wait_cyc(10);
        check("R9 sync strobe at A=B=0", nidx - i0, 1);
        enc_idx_n = 1'b1; wait_cyc(10);

        // R11: disabled index, both index modes
        idx_enable = 1'b0;
        for (int s = 0; s < 2; s++) begin
            idx_sync = s[0];
            i0 = nidx;
            enc_idx_n = 1'b0; wait_cyc(10);
            check("R11 index disabled", nidx - i0, 0);
            enc_idx_n = 1'b1; wait_cyc(10);
        end
        idx_enable = 1'b1;

        // R10: non-quadrature forces asynchronous index
        res_mode = 2'b00; idx_sync = 1'b1;
        enc_a = 1'b0; enc_b = 1'b1; wait_cyc(10);
        i0 = nidx;
        enc_idx_n = 1'b0; wait_cyc(1);
        check("R10 forced async in non-quadrature", idx_strobe, 1);
        enc_idx_n = 1'b1; wait_cyc(6);
        check("R10 forced async count", nidx - i0, 1);

        // R2 R3 R12: non-quadrature clock/direction, one-clock A pulses
        enc_a = 1'b1; enc_b = 1'b1;
        wait_cyc(1);
        check("R2 pulse one cycle after rise", cnt_pulse, 1);
        check("R2 direction from B high", cnt_up, 1);
        check("R12 cko follows A high", cko, 1);
        enc_a = 1'b0;
        wait_cyc(1);
        check("R12 cko follows A low", cko, 0);
        wait_cyc(4);
        p0 = pos; n0 = npulse; sum = 0;
        for (int i = 0; i < 9; i++) begin
            enc_b = (i % 3 == 0);
            sum += (i % 3 == 0) ? 1 : -1;
            enc_a = 1'b1; wait_cyc(1);
            enc_a = 1'b0; wait_cyc(1);
        end
        wait_cyc(4);
        check("R3 one-clock pulses counted", npulse - n0, 9);
        check("R2 net direction", pos - p0, sum);
        check("R2 last direction low", cnt_up, 0);

        finish_run();
    end
endmodule